// File: doc/BRIEF.md
# Dual-Mode Latch/Register Bus Buffer

This block is a parallel bus buffer that has one storage bit per lane. A shared active-low hold control (`hold_n`) picks how that bit is loaded. While `hold_n` is low the buffer flows through, and every lane takes its input on each sampling cycle. While `hold_n` is high the buffer acts as a register. A lane then loads only when the capture strobe `strobe` rises, and it holds its value at every other time. A shared active-low output-enable (`oe_n`) decides whether the bus is driven. The block has no internal tri-state. It presents the stored value together with one active-high drive flag, and the pad ring or the bus fabric applies that flag.

The whole block runs on a single system clock `clk`. `strobe`, `hold_n`, `oe_n` and `din` are sampled as synchronous levels on that clock. A strobe rise is a sample that is high where the previous sample was low. Every output comes from a register, so all modes have one cycle of latency. That includes flow-through: the bus carries the input that was sampled on the previous edge. An optional asynchronous clear gives a known start state.

Top module: `dual_mode_bus_buffer`

## Requirements
- R1: While `rst_n` is low, `dout` is all zeros and `drive_en` is 0.
- R2: If `hold_n` was 0 at a sampling edge, then after that edge `dout` equals the `din` sampled at that edge, whatever `strobe` was.
- R3: If `hold_n` was 1 at an edge, `strobe` was 1 at that edge and `strobe` was 0 at the previous edge, then after the edge `dout` equals the `din` sampled at that edge.
- R4: If `hold_n` is 1 and `strobe` stays high, `dout` does not change, whatever `din` does.
- R5: If `hold_n` is 1 and `strobe` stays low or falls, `dout` does not change.
- R6: After each edge, `drive_en` equals the inverse of the `oe_n` sampled at that edge. `oe_n` has no effect on the value of `dout`.
- R7: Storage keeps following the R2–R5 rules while `oe_n` is high. When the output is enabled again, the current stored value appears with no extra delay.
- R8: If `hold_n` rises while `strobe` is high, the value last loaded in flow-through mode is held. A later low-to-high transition of `strobe` loads new data.
- R9: The strobe history is cleared to "high" on reset. A strobe that is already high when reset is released does not count as a rise.
- R10: All `WIDTH` lanes share the same controls, and each lane carries its own input bit to its own output bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| din | input | WIDTH | Lane data inputs |
| strobe | input | 1 | Capture strobe, active on a rise while holding |
| hold_n | input | 1 | Low: flow-through; high: register on strobe rise |
| oe_n | input | 1 | Output enable, active low |
| dout | output | WIDTH | Stored lane values |
| drive_en | output | 1 | Active-high bus drive flag |

## Verification
The bench builds the block with the default `WIDTH` of 18. At that width the walking-one patterns and the pseudo-random words reach every lane, so a lane that is swapped or tied shows up on the compare. The bench's reference model keeps its own last-strobe flag and stored word, and the RTL's output bus is compared against that model on every cycle. This brings into reach mode changes in the middle of a strobe phase, strobe falls that must not load, and a reset that is released while the strobe is high.

// File: rtl/dmb_pkg.sv
package dmb_pkg;

    typedef enum logic [1:0] {
        LOAD_FLOW = 2'd0,
        LOAD_EDGE = 2'd1,
        LOAD_KEEP = 2'd2
    } load_e;

    function automatic load_e pick_load(input logic hold_n, input logic rise);
        if (!hold_n)
            return LOAD_FLOW;
        else if (rise)
            return LOAD_EDGE;
        else
            return LOAD_KEEP;
    endfunction

endpackage

// File: rtl/dmb_strobe_edge.sv
module dmb_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic rise
);
    typedef struct packed {
        logic last;
    } edge_st;

    edge_st st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.last = strobe;
        rise      = strobe && !st_q.last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{last: 1'b1};
        else
            st_q <= st_d;
    end

    // R9: a rise needs a low sample since reset
    a_r9_rise_needs_low: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/dmb_lane.sv
module dmb_lane
    import dmb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  load_e sel,
    input  logic  d,
    output logic  q
);
    typedef struct packed {
        logic bit_v;
    } lane_st;

    lane_st st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (sel)
            LOAD_FLOW: st_d.bit_v = d;
            LOAD_EDGE: st_d.bit_v = d;
            default:   st_d.bit_v = st_q.bit_v;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{bit_v: 1'b0};
        else
            st_q <= st_d;
    end

    assign q = st_q.bit_v;

    a_r2_flow_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == LOAD_FLOW) |=> q == $past(d));
    a_r4_keep_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == LOAD_KEEP) |=> $stable(q));
endmodule

// File: rtl/dmb_drive.sv
module dmb_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic oe_n,
    output logic drive_en
);
    typedef struct packed {
        logic en;
    } drv_st;

    drv_st st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.en = !oe_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{en: 1'b0};
        else
            st_q <= st_d;
    end

    assign drive_en = st_q.en;
endmodule

// File: rtl/dual_mode_bus_buffer.sv
module dual_mode_bus_buffer
    import dmb_pkg::*;
#(
    parameter int WIDTH = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    input  logic             strobe,
    input  logic             hold_n,
    input  logic             oe_n,
    output logic [WIDTH-1:0] dout,
    output logic             drive_en
);
    localparam int LANES = WIDTH;

    logic  rise;
    load_e load_sel;

    dmb_strobe_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe),
        .rise   (rise)
    );

    always_comb begin
        load_sel = pick_load(hold_n, rise);
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        dmb_lane u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .sel   (load_sel),
            .d     (din[g]),
            .q     (dout[g])
        );
    end

    dmb_drive u_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .oe_n     (oe_n),
        .drive_en (drive_en)
    );

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |-> (dout == '0 && !drive_en));
    a_r3_capture_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_n && rise) |=> dout == $past(din));
    a_r5_keep_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_n && !strobe) |=> $stable(dout));
    a_r6_drive_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |=> !drive_en);
endmodule

// File: tb/sim_dual_mode_bus_buffer.sv
module sim_dual_mode_bus_buffer;
    localparam int W   = 18;
    localparam int PER = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] din = '0;
    logic         strobe = 1'b0;
    logic         hold_n = 1'b0;
    logic         oe_n = 1'b1;
    logic [W-1:0] dout;
    logic         drive_en;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    logic [W-1:0] m_store = '0;
    bit           m_last = 1;
    bit           m_drv = 0;
    string        m_tag = "R1";

    always #(PER/2) clk = ~clk;

    dual_mode_bus_buffer #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .din(din), .strobe(strobe),
        .hold_n(hold_n), .oe_n(oe_n), .dout(dout), .drive_en(drive_en)
    );

    task automatic compare();
        checks++;
        if (dout !== m_store || drive_en !== m_drv) begin
            errors++;
            $display("FAIL %s: dout=%h drive_en=%b expected dout=%h drive_en=%b",
                     m_tag, dout, drive_en, m_store, m_drv);
        end
    endtask

    // check at negedge, then drive and advance the model for the next edge
    task automatic step(input logic [W-1:0] d, input logic hn, input logic st,
                        input logic oen, input string tag);
        @(negedge clk);
        compare();
        din = d; hold_n = hn; strobe = st; oe_n = oen;
        if (!hn)
            m_store = d;
        else if (st && !m_last)
            m_store = d;
        m_last = st;
        m_drv  = !oen;
        m_tag  = tag;
    endtask

    task automatic do_reset(input logic st, input logic hn);
        @(negedge clk);
        rst_n = 1'b0; strobe = st; hold_n = hn; oe_n = 1'b0; din = '1;
        m_store = '0; m_last = 1; m_drv = 0; m_tag = "R1";
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            compare();
        end
        rst_n = 1'b1;
        m_last = 1;
        if (!hn) m_store = din;
        m_last = st;
        m_drv = 1;
    endtask

    function automatic logic [W-1:0] rnd();
        return W'($urandom);
    endfunction

    initial begin
        do_reset(1'b0, 1'b1);
        // R2: flow-through ignores strobe
        for (int i = 0; i < 8; i++)
            step(rnd(), 1'b0, i[0], 1'b0, "R2");
        // R3: capture only on strobe rise
        for (int i = 0; i < 8; i++)
            step(rnd(), 1'b1, i[0], 1'b0, "R3");
        // R4: strobe held high
        step(rnd(), 1'b1, 1'b1, 1'b0, "R4");
        for (int i = 0; i < 4; i++)
            step(rnd(), 1'b1, 1'b1, 1'b0, "R4");
        // R5: strobe falls then stays low
        for (int i = 0; i < 4; i++)
            step(rnd(), 1'b1, 1'b0, 1'b0, "R5");
        // R6 / R7: disabled bus, storage still moves
        step(18'h2a5a5, 1'b0, 1'b0, 1'b1, "R6");
        step(18'h15a5a, 1'b0, 1'b1, 1'b1, "R7");
        step(18'h3c3c3, 1'b1, 1'b0, 1'b1, "R7");
        step(18'h0f0f0, 1'b1, 1'b1, 1'b1, "R7");
        step(18'h11111, 1'b1, 1'b1, 1'b0, "R7");
        step(18'h22222, 1'b1, 1'b1, 1'b1, "R6");
        step(18'h33333, 1'b1, 1'b1, 1'b0, "R6");
        // R8: hold_n rises mid strobe-high phase
        step(18'h0abcd, 1'b0, 1'b1, 1'b0, "R8");
        step(18'h3ffff, 1'b1, 1'b1, 1'b0, "R8");
        step(18'h12345, 1'b1, 1'b1, 1'b0, "R8");
        step(18'h00001, 1'b1, 1'b0, 1'b0, "R8");
        step(18'h2fedc, 1'b1, 1'b1, 1'b0, "R8");
        step(18'h2fedc, 1'b1, 1'b1, 1'b0, "R8");
        // mode switch back to flow mid strobe-low phase
        step(18'h1beef, 1'b1, 1'b0, 1'b0, "R8");
        step(18'h0cafe, 1'b0, 1'b0, 1'b0, "R2");
        step(18'h0cafe, 1'b0, 1'b0, 1'b0, "R2");
        // R9: reset released with strobe already high
        do_reset(1'b1, 1'b1);
        step(18'h3aaaa, 1'b1, 1'b1, 1'b0, "R9");
        step(18'h35555, 1'b1, 1'b1, 1'b0, "R9");
        step(18'h35555, 1'b1, 1'b0, 1'b0, "R9");
        step(18'h01357, 1'b1, 1'b1, 1'b0, "R9");
        step(18'h01357, 1'b1, 1'b1, 1'b0, "R9");
        // R10: walking one across every lane
        for (int i = 0; i < W; i++)
            step(W'(1) << i, 1'b0, 1'b0, 1'b0, "R10");
        for (int i = 0; i < W; i++)
            step(~(W'(1) << i), 1'b0, 1'b1, 1'b0, "R10");
        @(negedge clk);
        compare();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        #(PER * 20000);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule